// File: doc/BRIEF.md
# Daisy-Chain Frame CRC Codec

This block forms and checks the 32-bit words that travel on a daisy-chained battery-monitor serial bus, where every word carries an 8-bit CRC. The encoder side takes a logical device address, a register address, a data byte and a broadcast flag. It returns one complete command word with the CRC and a fixed three-bit tail. The checker side takes each 32-bit word read back from the chain and recomputes its CRC. It reports whether the CRC matches, and on a match it splits the word into its address, register, data, channel and conversion-result fields.

The CRC uses the generator x^8+x^5+x^3+x^2+x+1 (0x2F), processed MSB first and starting from zero. The message field is padded with zeros on the left to 24 bits and taken one byte at a time. The high byte is reduced through eight shift steps. That result XOR the middle byte is reduced again. The low byte is then XORed onto the second result with no third reduction. Device addresses go on the wire with their five bits in reverse order. The encoder reverses them on the way in, and the checker reverses them back. Shifting the words on and off the wire and sequencing the chain are left to neighbouring logic.

Top module: `frame_crc_codec`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `enc_ready`, `enc_word_valid` and `chk_out_valid` are 0, and `enc_word` and every checker field output are 0.
- R2: `enc_ready` is 1 from the first edge after reset is released. An input set is accepted on an edge where `enc_valid` and `enc_ready` are both 1. `enc_word_valid` is 1 in exactly the cycle after each accept and 0 otherwise.
- R3: In an encoded word, bits 31:27 hold the device address with its bit order reversed (input bit 0 lands in word bit 31), bits 26:21 hold the register address, bits 20:13 hold the data byte, bit 12 holds the broadcast flag, and bit 11 is 0.
- R4: In an encoded word, bits 10:3 hold the CRC of the 21-bit field in bits 31:11, formed by the two-reduction, one-XOR byte procedure with polynomial 0x2F. Bits 2:0 are binary 010.
- R5: `enc_word` keeps its value in every cycle that follows a cycle with no accept.
- R6: `chk_out_valid` is 1 in exactly the cycle after each cycle with `chk_valid` high, and 0 otherwise. The checker outputs in that cycle describe the word that was presented.
- R7: `chk_crc_ok` is 1 exactly when the CRC of bits 31:10 of the presented word (22 bits, same procedure) equals bits 9:2. Bits 1:0 do not take part.
- R8: For a word that passes, `chk_dev_addr` is bits 31:27 with their order reversed back, `chk_reg_addr` is bits 26:21, `chk_reg_data` is bits 20:13, `chk_channel` is bits 26:23 and `chk_result` is bits 22:11.
- R9: For a word that fails, all decoded field outputs are 0 while `chk_out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid | input | 1 | Encoder field set is offered |
| enc_ready | output | 1 | Encoder can accept a field set |
| enc_dev_addr | input | 5 | Logical device address |
| enc_reg_addr | input | 6 | Target register address |
| enc_data | input | 8 | Data byte to write |
| enc_bcast | input | 1 | Write applies to every device in the chain |
| enc_word_valid | output | 1 | One-cycle strobe: a new command word is present |
| enc_word | output | 32 | Encoded command word |
| chk_valid | input | 1 | A readback word is presented |
| chk_word | input | 32 | Readback word to check |
| chk_out_valid | output | 1 | One-cycle strobe: checker outputs are valid |
| chk_crc_ok | output | 1 | Readback CRC matched |
| chk_dev_addr | output | 5 | Logical device address of a good word |
| chk_reg_addr | output | 6 | Register address of a good register readback |
| chk_reg_data | output | 8 | Data byte of a good register readback |
| chk_channel | output | 4 | Channel number of a good conversion readback |
| chk_result | output | 12 | Conversion result of a good conversion readback |

## Verification
The encoder is swept over all 32 device addresses with both broadcast settings, over every register address, and over walking-one data bytes. The address sweep shows whether the bit reversal is correct. The other sweeps show whether the fields overlap and whether each message byte reaches the CRC through the right reduction. The checker first gets correctly formed words built from varied field patterns, which tests the field extraction. Each of those words is then presented again with every single bit flipped in turn. A flip in bits 31:2 must be caught, and a flip in bits 1:0 must not. This separates a CRC window that is too wide or too narrow, and a missing or extra reduction on the low byte, from a correct implementation.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
  localparam int WORD_W   = 32;
  localparam int DEV_W    = 5;
  localparam int REG_W    = 6;
  localparam int BYTE_W   = 8;
  localparam int CH_W     = 4;
  localparam int RES_W    = 12;
  localparam int CRC_W    = 8;
  localparam int MSG_W    = 3 * BYTE_W;
  localparam logic [7:0] DEFAULT_POLY = 8'h2F;

  // field positions (upper bit of each field)
  localparam int DEV_HI   = WORD_W - 1;
  localparam int DEV_LO   = DEV_HI - DEV_W + 1;
  localparam int REG_HI   = DEV_LO - 1;
  localparam int REG_LO   = REG_HI - REG_W + 1;
  localparam int DAT_HI   = REG_LO - 1;
  localparam int DAT_LO   = DAT_HI - BYTE_W + 1;
  localparam int BC_BIT   = DAT_LO - 1;
  localparam int CH_HI    = REG_HI;
  localparam int CH_LO    = CH_HI - CH_W + 1;
  localparam int RES_HI   = CH_LO - 1;
  localparam int RES_LO   = RES_HI - RES_W + 1;

  // write: CRC over 31:11, CRC at 10:3, tail 2:0
  localparam int WR_MSG_LO = 11;
  localparam int WR_CRC_LO = 3;
  localparam logic [2:0] WR_TAIL = 3'b010;
  // read: CRC over 31:10, CRC at 9:2
  localparam int RD_MSG_LO = 10;
  localparam int RD_CRC_LO = 2;

  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [REG_W-1:0]  regad;
    logic [BYTE_W-1:0] data;
    logic [CH_W-1:0]   chan;
    logic [RES_W-1:0]  result;
  } rd_fields_t;
endpackage

// File: rtl/crc8_byte_step.sv
module crc8_byte_step #(
  parameter int         W    = 8,
  parameter logic [7:0] POLY = 8'h2F
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [0:W];
  assign stg[0] = din;
  for (genvar i = 0; i < W; i++) begin : g_shift
    assign stg[i+1] = stg[i][W-1] ? ({stg[i][W-2:0], 1'b0} ^ POLY[W-1:0])
                                  : {stg[i][W-2:0], 1'b0};
  end
  assign dout = stg[W];
endmodule

// File: rtl/frame_crc_calc.sv
module frame_crc_calc
  import frame_crc_pkg::*;
#(
  parameter logic [7:0] POLY = DEFAULT_POLY
) (
  input  logic [MSG_W-1:0] msg,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] r_hi, r_mid;

  crc8_byte_step #(.W(CRC_W), .POLY(POLY)) i_step_hi (
    .din (msg[MSG_W-1 -: BYTE_W]),
    .dout(r_hi)
  );
  crc8_byte_step #(.W(CRC_W), .POLY(POLY)) i_step_mid (
    .din (r_hi ^ msg[2*BYTE_W-1 -: BYTE_W]),
    .dout(r_mid)
  );
  // low byte folded in without a further reduction
  assign crc = r_mid ^ msg[BYTE_W-1:0];
endmodule

// File: rtl/frame_word_encoder.sv
module frame_word_encoder
  import frame_crc_pkg::*;
#(
  parameter logic [7:0] POLY = DEFAULT_POLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0] data,
  input  logic              bcast,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam int FIELD_W = WORD_W - WR_MSG_LO;

  logic [DEV_W-1:0]   dev_rev;
  logic [FIELD_W-1:0] field;
  logic [MSG_W-1:0]   msg;
  logic [CRC_W-1:0]   crc;
  logic               accept;

  for (genvar i = 0; i < DEV_W; i++) begin : g_rev
    assign dev_rev[DEV_W-1-i] = dev_addr[i];
  end

  assign field = {dev_rev, reg_addr, data, bcast, 1'b0};
  assign msg   = {{(MSG_W-FIELD_W){1'b0}}, field};

  frame_crc_calc #(.POLY(POLY)) i_crc (.msg(msg), .crc(crc));

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= accept;
      if (accept) out_word <= {field, crc, WR_TAIL};
    end
  end
endmodule

// File: rtl/frame_word_checker.sv
module frame_word_checker
  import frame_crc_pkg::*;
#(
  parameter logic [7:0] POLY = DEFAULT_POLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] word,
  output logic              out_valid,
  output logic              crc_ok,
  output rd_fields_t        fields
);
  localparam int FIELD_W = WORD_W - RD_MSG_LO;

  logic [MSG_W-1:0] msg;
  logic [CRC_W-1:0] crc;
  logic             match;
  logic [DEV_W-1:0] dev_log;
  rd_fields_t       dec;

  assign msg   = {{(MSG_W-FIELD_W){1'b0}}, word[WORD_W-1:RD_MSG_LO]};
  frame_crc_calc #(.POLY(POLY)) i_crc (.msg(msg), .crc(crc));
  assign match = (crc == word[RD_CRC_LO +: CRC_W]);

  for (genvar i = 0; i < DEV_W; i++) begin : g_rev
    assign dev_log[i] = word[DEV_HI-i];
  end

  always_comb begin
    dec        = '0;
    dec.dev    = dev_log;
    dec.regad  = word[REG_HI:REG_LO];
    dec.data   = word[DAT_HI:DAT_LO];
    dec.chan   = word[CH_HI:CH_LO];
    dec.result = word[RES_HI:RES_LO];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      crc_ok    <= 1'b0;
      fields    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        crc_ok <= match;
        fields <= match ? dec : '0;
      end
    end
  end
endmodule

// File: rtl/frame_crc_codec.sv
module frame_crc_codec
  import frame_crc_pkg::*;
#(
  parameter logic [7:0] POLY = DEFAULT_POLY
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enc_valid,
  output logic        enc_ready,
  input  logic [4:0]  enc_dev_addr,
  input  logic [5:0]  enc_reg_addr,
  input  logic [7:0]  enc_data,
  input  logic        enc_bcast,
  output logic        enc_word_valid,
  output logic [31:0] enc_word,
  input  logic        chk_valid,
  input  logic [31:0] chk_word,
  output logic        chk_out_valid,
  output logic        chk_crc_ok,
  output logic [4:0]  chk_dev_addr,
  output logic [5:0]  chk_reg_addr,
  output logic [7:0]  chk_reg_data,
  output logic [3:0]  chk_channel,
  output logic [11:0] chk_result
);
  rd_fields_t rd;

  frame_word_encoder #(.POLY(POLY)) i_enc (
    .clk(clk), .rst(rst),
    .in_valid(enc_valid), .in_ready(enc_ready),
    .dev_addr(enc_dev_addr), .reg_addr(enc_reg_addr),
    .data(enc_data), .bcast(enc_bcast),
    .out_valid(enc_word_valid), .out_word(enc_word)
  );

  frame_word_checker #(.POLY(POLY)) i_chk (
    .clk(clk), .rst(rst),
    .in_valid(chk_valid), .word(chk_word),
    .out_valid(chk_out_valid), .crc_ok(chk_crc_ok), .fields(rd)
  );

  assign chk_dev_addr = rd.dev;
  assign chk_reg_addr = rd.regad;
  assign chk_reg_data = rd.data;
  assign chk_channel  = rd.chan;
  assign chk_result   = rd.result;
endmodule

// File: rtl/frame_crc_codec_sva.sv
module frame_crc_codec_sva (
  input logic        clk,
  input logic        rst,
  input logic        enc_valid,
  input logic        enc_ready,
  input logic [4:0]  enc_dev_addr,
  input logic [5:0]  enc_reg_addr,
  input logic [7:0]  enc_data,
  input logic        enc_bcast,
  input logic        enc_word_valid,
  input logic [31:0] enc_word,
  input logic        chk_valid,
  input logic [31:0] chk_word,
  input logic        chk_out_valid,
  input logic        chk_crc_ok,
  input logic [4:0]  chk_dev_addr,
  input logic [5:0]  chk_reg_addr,
  input logic [7:0]  chk_reg_data,
  input logic [3:0]  chk_channel,
  input logic [11:0] chk_result
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!enc_ready && !enc_word_valid && !chk_out_valid));

  assert_strobe_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (enc_valid && enc_ready) |=> enc_word_valid);

  assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !(enc_valid && enc_ready) |=> !enc_word_valid);

  assert_fields_placed_R3: assert property (@(posedge clk) disable iff (rst)
    (enc_valid && enc_ready) |=> (enc_word[12] == $past(enc_bcast) &&
                                  enc_word[20:13] == $past(enc_data) &&
                                  enc_word[26:21] == $past(enc_reg_addr)));

  assert_tail_pattern_R4: assert property (@(posedge clk) disable iff (rst)
    enc_word_valid |-> enc_word[2:0] == 3'b010);

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(enc_valid && enc_ready) |=> $stable(enc_word));

  assert_chk_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_out_valid);

  assert_chk_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !chk_out_valid);

  assert_bad_word_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (chk_out_valid && !chk_crc_ok) |->
      (chk_dev_addr == '0 && chk_reg_addr == '0 && chk_reg_data == '0 &&
       chk_channel == '0 && chk_result == '0));
endmodule

bind frame_crc_codec frame_crc_codec_sva i_sva (.*);

// File: tb/test_frame_crc_codec.sv
module test_frame_crc_codec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_valid = 1'b0;
  logic        enc_ready;
  logic [4:0]  enc_dev_addr = '0;
  logic [5:0]  enc_reg_addr = '0;
  logic [7:0]  enc_data = '0;
  logic        enc_bcast = 1'b0;
  logic        enc_word_valid;
  logic [31:0] enc_word;
  logic        chk_valid = 1'b0;
  logic [31:0] chk_word = '0;
  logic        chk_out_valid;
  logic        chk_crc_ok;
  logic [4:0]  chk_dev_addr;
  logic [5:0]  chk_reg_addr;
  logic [7:0]  chk_reg_data;
  logic [3:0]  chk_channel;
  logic [11:0] chk_result;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  frame_crc_codec i_frame_crc_codec (.*);

  function automatic logic [7:0] ref_reduce(input logic [7:0] v);
    logic [7:0] c = v;
    for (int k = 0; k < 8; k++)
      c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] ref_crc(input logic [23:0] m);
    logic [7:0] c;
    c = ref_reduce(m[23:16]);
    c = ref_reduce(c ^ m[15:8]);
    return c ^ m[7:0];
  endfunction

  function automatic logic [4:0] rev5(input logic [4:0] a);
    return {a[0], a[1], a[2], a[3], a[4]};
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_enc(input logic [4:0] d, input logic [5:0] r,
                          input logic [7:0] v, input logic b);
    logic [31:0] exp;
    logic [20:0] fld;
    fld = {rev5(d), r, v, b, 1'b0};
    exp = {fld, ref_crc({3'b000, fld}), 3'b010};
    @(negedge clk);
    enc_valid = 1'b1; enc_dev_addr = d; enc_reg_addr = r;
    enc_data = v; enc_bcast = b;
    @(negedge clk);
    enc_valid = 1'b0;
    check(enc_word_valid == 1'b1, "R2 strobe", {31'b0, enc_word_valid}, 32'd1);
    check(enc_word[31:11] == fld, "R3 fields", enc_word, exp);
    check(enc_word[10:0] == exp[10:0], "R4 crc+tail", enc_word, exp);
  endtask

  task automatic send_chk(input logic [31:0] w);
    logic [7:0]  c;
    logic        ok_e;
    c    = ref_crc({2'b00, w[31:10]});
    ok_e = (c == w[9:2]);
    @(negedge clk);
    chk_valid = 1'b1; chk_word = w;
    @(negedge clk);
    chk_valid = 1'b0;
    check(chk_out_valid == 1'b1, "R6 strobe", {31'b0, chk_out_valid}, 32'd1);
    check(chk_crc_ok == ok_e, "R7 crc_ok", {31'b0, chk_crc_ok}, {31'b0, ok_e});
    if (ok_e) begin
      check(chk_dev_addr == rev5(w[31:27]) && chk_reg_addr == w[26:21] &&
            chk_reg_data == w[20:13] && chk_channel == w[26:23] &&
            chk_result == w[22:11], "R8 fields",
            {chk_dev_addr, chk_reg_addr, chk_reg_data, chk_channel, chk_result[8:0]},
            {rev5(w[31:27]), w[26:21], w[20:13], w[26:23], w[19:11]});
    end else begin
      check({chk_dev_addr, chk_reg_addr, chk_reg_data, chk_channel, chk_result} == '0,
            "R9 zero fields",
            {chk_dev_addr, chk_reg_addr, chk_reg_data, chk_channel, chk_result[8:0]},
            32'd0);
    end
  endtask

  function automatic logic [31:0] good_word(input logic [21:0] top, input logic [1:0] lo);
    return {top, ref_crc({2'b00, top}), lo};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!enc_ready && !enc_word_valid && !chk_out_valid && enc_word == '0 &&
          {chk_crc_ok, chk_dev_addr, chk_reg_addr, chk_reg_data, chk_channel, chk_result} == '0,
          "R1 reset", {29'b0, enc_ready, enc_word_valid, chk_out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(enc_ready == 1'b1, "R2 ready", {31'b0, enc_ready}, 32'd1);

    // encoder: every device address, both broadcast values
    for (int d = 0; d < 32; d++)
      for (int b = 0; b < 2; b++)
        send_enc(d[4:0], 6'((d * 7 + b) % 64), 8'((d * 37 + b * 91) % 256), b[0]);
    // every register address
    for (int r = 0; r < 64; r++)
      send_enc(5'(r % 32), r[5:0], 8'(255 - r), 1'b0);
    // walking-one data
    for (int k = 0; k < 8; k++)
      send_enc(5'd31, 6'd0, 8'(1 << k), 1'b0);
    // all-ones address, other fields zero (idle-style word)
    send_enc(5'd31, 6'd0, 8'd0, 1'b0);

    // R5 hold and R2 strobe drop with no accept
    begin
      logic [31:0] held;
      held = enc_word;
      repeat (3) @(negedge clk);
      check(enc_word == held, "R5 hold", enc_word, held);
      check(enc_word_valid == 1'b0, "R2 strobe single", {31'b0, enc_word_valid}, 32'd0);
    end

    // checker: good words, then every single-bit flip
    for (int p = 0; p < 6; p++) begin
      logic [31:0] w;
      w = good_word(22'((p * 32'h2A5F1 + 32'h1357) & 32'h3FFFFF), 2'(p));
      send_chk(w);
      for (int bit_i = 0; bit_i < 32; bit_i++)
        send_chk(w ^ (32'd1 << bit_i));
    end
    send_chk(good_word(22'h3FFFFF, 2'b11));
    send_chk(good_word(22'h000000, 2'b00));

    // R6 strobe drops when no word is presented
    @(negedge clk);
    check(chk_out_valid == 1'b0, "R6 quiet", {31'b0, chk_out_valid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule